// File: doc/BRIEF.md
# Transmit Channel Teardown and Error Sequencer

This block controls the closing and fault handling of one transmit DMA channel. It does not move data. A teardown request lets the work in flight finish, or gives it up. The block may then emit a one-beat marker packet downstream. It posts a completion message either at once or only after the remote paired peripheral returns a status message. The completion carries a programmed 16-bit completion queue number.

A transfer error always raises an error event tagged with a programmed event number. Depending on a mode bit, the error also does one of two things. It can discard the current work and let the channel carry on. Or it can freeze the channel until software releases it.

The channel state machine has seven states: `ST_IDLE`, `ST_ACTIVE`, `ST_TD_DRAIN`, `ST_TD_SEND_PKT`, `ST_TD_WAIT_REMOTE`, `ST_TD_COMPLETE` and `ST_PAUSED`. Its transitions are:

- IDLE→ACTIVE when `chan_en` rises.
- ACTIVE→IDLE when `chan_en` falls.
- ACTIVE→TD_DRAIN on `td_req`.
- ACTIVE→PAUSED on an error in pause mode.
- TD_DRAIN→TD_SEND_PKT, →TD_WAIT_REMOTE or →TD_COMPLETE once `work_busy` is low.
- TD_SEND_PKT→TD_WAIT_REMOTE or →TD_COMPLETE.
- TD_WAIT_REMOTE→TD_COMPLETE on `remote_sts`.
- TD_COMPLETE→IDLE.
- PAUSED→ACTIVE on `unpause`.
- PAUSED→TD_COMPLETE on `td_req`.
- PAUSED→IDLE when `chan_en` falls.

Top module: `txch_td_ctrl`

## Requirements
- R1: After reset no output is active. The mode bits read 0, the queue number reads 0, and the error event number reads FFFFh.
- R2: After a teardown request is accepted in ACTIVE, no marker and no completion appear while `work_busy` is 1.
- R3: With mode bit 1 (`no_marker`) at 0, `td_marker` pulses for exactly one cycle once draining ends, and before the completion.
- R4: With mode bit 1 at 1, no marker is emitted during teardown.
- R5: With mode bit 0 (`wait_remote`) at 0, the completion follows without waiting. With it at 1, the completion is held until a `remote_sts` pulse.
- R6: `cpl_valid` pulses for one cycle, with `cpl_qnum` equal to the programmed queue number.
- R7: With mode bit 2 (`pause_on_err`) at 0, an error in ACTIVE pulses `drop_work` in the same cycle, and the channel stays ACTIVE.
- R8: With mode bit 2 at 1, an error in ACTIVE sets `paused` from the next cycle and gives no `drop_work`. An `unpause` pulse clears `paused` in the following cycle.
- R9: An error in any state other than IDLE gives one `err_evt_valid` pulse, in the cycle after the error, carrying the programmed number. The number FFFFh means "no event", and nothing is emitted.
- R10: Configuration writes are applied only while `chan_en` is 0. Select 0 writes the mode bits, select 1 the queue number, select 2 the event number. Writes while `chan_en` is 1 are ignored.
- R11: A teardown request while PAUSED gives the completion in the next cycle. There is no marker and no remote wait, whatever the mode.
- R12: A teardown request and an error in the same ACTIVE cycle start the teardown, and the error event is still emitted. The channel never pauses.
- R13: After a completion, the channel ignores further teardown requests until `chan_en` is lowered and raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable; a rising edge activates the channel |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 mode, 1 queue number, 2 event number |
| cfg_wdata | input | CW (16) | Configuration write data |
| td_req | input | 1 | Teardown request pulse |
| work_busy | input | 1 | Current work is still in flight |
| remote_sts | input | 1 | Status message from the remote peer |
| xfer_err | input | 1 | Transfer error pulse |
| unpause | input | 1 | Software release of a paused channel |
| drop_work | output | 1 | Discard current work (drop mode) |
| paused | output | 1 | Channel is paused |
| td_marker | output | 1 | One-beat teardown marker packet |
| cpl_valid | output | 1 | Teardown completion message |
| cpl_qnum | output | QW (16) | Completion queue number |
| err_evt_valid | output | 1 | Error event pulse |
| err_evt_num | output | EW (16) | Error event number |

## Verification
An error and a teardown request can land in the same ACTIVE cycle. The bench drives both pulses on one edge with pause mode selected. It expects this order: the error event one cycle later, then the marker, then the completion. It samples `paused` on every following cycle to confirm that the pause never took hold. The scoreboard rejects any output that has no queued expectation, so an early marker, a lost event or a stray pause shows up as a mismatch or as an unexpected item.

// File: rtl/txch_td_pkg.sv
package txch_td_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_TD_DRAIN,
        ST_TD_SEND_PKT,
        ST_TD_WAIT_REMOTE,
        ST_TD_COMPLETE,
        ST_PAUSED
    } td_state_e;

    // bit2 pause_on_err, bit1 no_marker, bit0 wait_remote
    typedef struct packed {
        logic pause_on_err;
        logic no_marker;
        logic wait_remote;
    } td_mode_t;

    localparam int MODE_W = $bits(td_mode_t);

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_QNUM = 2'd1;
    localparam logic [1:0] SEL_EVT  = 2'd2;

endpackage

// File: rtl/txch_td_cfg.sv
module txch_td_cfg
    import txch_td_pkg::*;
#(
    parameter int CW = 16,
    parameter int QW = 16,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [CW-1:0] wr_data,
    output td_mode_t      mode,
    output logic [QW-1:0] qnum,
    output logic [EW-1:0] evt_num
);

    localparam logic [EW-1:0] EVT_NONE = '1;

    logic unused_hi;
    assign unused_hi = ^wr_data[CW-1:MODE_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= '0;
            qnum    <= '0;
            evt_num <= EVT_NONE;
        end else if (wr_en && !chan_en) begin
            case (wr_sel)
                SEL_MODE: mode    <= td_mode_t'(wr_data[MODE_W-1:0]);
                SEL_QNUM: qnum    <= wr_data[QW-1:0];
                SEL_EVT:  evt_num <= wr_data[EW-1:0];
                default:  ;
            endcase
        end
    end

    AST_CFG_LOCK_QNUM: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(qnum)); // R10
    AST_CFG_LOCK_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(evt_num)); // R10
    AST_CFG_LOCK_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(mode)); // R10

endmodule

// File: rtl/txch_td_evt.sv
module txch_td_evt #(
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err,
    input  logic          live,
    input  logic [EW-1:0] num,
    output logic          evt_valid,
    output logic [EW-1:0] evt_num
);

    localparam logic [EW-1:0] EVT_NONE = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_num   <= '0;
        end else begin
            evt_valid <= err && live && (num != EVT_NONE);
            if (err && live) begin
                evt_num <= num;
            end
        end
    end

    AST_EVT_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(err)); // R9
    AST_EVT_NOT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_num != EVT_NONE)); // R9

endmodule

// File: rtl/txch_td_fsm.sv
module txch_td_fsm
    import txch_td_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     chan_en,
    input  logic     td_req,
    input  logic     work_busy,
    input  logic     remote_sts,
    input  logic     xfer_err,
    input  logic     unpause,
    input  td_mode_t mode,
    output logic     marker,
    output logic     cpl,
    output logic     paused,
    output logic     drop_work,
    output logic     live
);

    td_state_e state, nxt;
    logic      en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            en_q  <= 1'b0;
        end else begin
            state <= nxt;
            en_q  <= chan_en;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (chan_en && !en_q) nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!chan_en)                            nxt = ST_IDLE;
                else if (td_req)                         nxt = ST_TD_DRAIN;
                else if (xfer_err && mode.pause_on_err)  nxt = ST_PAUSED;
            end
            ST_TD_DRAIN: begin
                if (!work_busy) begin
                    if (!mode.no_marker)      nxt = ST_TD_SEND_PKT;
                    else if (mode.wait_remote) nxt = ST_TD_WAIT_REMOTE;
                    else                       nxt = ST_TD_COMPLETE;
                end
            end
            ST_TD_SEND_PKT: begin
                nxt = mode.wait_remote ? ST_TD_WAIT_REMOTE : ST_TD_COMPLETE;
            end
            ST_TD_WAIT_REMOTE: begin
                if (remote_sts) nxt = ST_TD_COMPLETE;
            end
            ST_TD_COMPLETE: begin
                nxt = ST_IDLE;
            end
            ST_PAUSED: begin
                if (!chan_en)     nxt = ST_IDLE;
                else if (td_req)  nxt = ST_TD_COMPLETE;
                else if (unpause) nxt = ST_ACTIVE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        marker    = (state == ST_TD_SEND_PKT);
        cpl       = (state == ST_TD_COMPLETE);
        paused    = (state == ST_PAUSED);
        drop_work = (state == ST_ACTIVE) && xfer_err && !mode.pause_on_err;
        live      = (state != ST_IDLE);
    end

    AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TD_DRAIN && work_busy) |=> (state == ST_TD_DRAIN)); // R2
    AST_REMOTE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TD_WAIT_REMOTE && !remote_sts) |=> !cpl); // R5
    AST_PAUSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && chan_en && xfer_err && mode.pause_on_err && !td_req) |=> paused); // R8
    AST_CPL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpl |=> (state == ST_IDLE)); // R6
    AST_PAUSED_TD: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && chan_en && td_req) |=> cpl); // R11
    AST_MARKER_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        marker |=> (!marker && !paused)); // R3

endmodule

// File: rtl/txch_td_ctrl.sv
module txch_td_ctrl
    import txch_td_pkg::*;
#(
    parameter int CW = 16,
    parameter int QW = 16,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [CW-1:0] cfg_wdata,
    input  logic          td_req,
    input  logic          work_busy,
    input  logic          remote_sts,
    input  logic          xfer_err,
    input  logic          unpause,
    output logic          drop_work,
    output logic          paused,
    output logic          td_marker,
    output logic          cpl_valid,
    output logic [QW-1:0] cpl_qnum,
    output logic          err_evt_valid,
    output logic [EW-1:0] err_evt_num
);

    td_mode_t      mode;
    logic [EW-1:0] evt_cfg;
    logic          live;

    txch_td_cfg #(.CW(CW), .QW(QW), .EW(EW)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_en (chan_en),
        .wr_en   (cfg_wr),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .mode    (mode),
        .qnum    (cpl_qnum),
        .evt_num (evt_cfg)
    );

    txch_td_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .td_req     (td_req),
        .work_busy  (work_busy),
        .remote_sts (remote_sts),
        .xfer_err   (xfer_err),
        .unpause    (unpause),
        .mode       (mode),
        .marker     (td_marker),
        .cpl        (cpl_valid),
        .paused     (paused),
        .drop_work  (drop_work),
        .live       (live)
    );

    txch_td_evt #(.EW(EW)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .err       (xfer_err),
        .live      (live),
        .num       (evt_cfg),
        .evt_valid (err_evt_valid),
        .evt_num   (err_evt_num)
    );

endmodule

// File: tb/txch_td_ctrl_tb_top.sv
module txch_td_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int K_DROP = 0, K_EVT = 1, K_MARK = 2, K_CPL = 3;

    typedef struct {
        int          kind;
        logic [15:0] data;
        string       req;
    } exp_t;

    logic clk = 0, rst_n = 0;
    logic chan_en = 0, cfg_wr = 0, td_req = 0, work_busy = 0;
    logic remote_sts = 0, xfer_err = 0, unpause = 0;
    logic [1:0]  cfg_sel = 0;
    logic [15:0] cfg_wdata = 0;
    logic drop_work, paused, td_marker, cpl_valid, err_evt_valid;
    logic [15:0] cpl_qnum, err_evt_num;

    int checks = 0, errors = 0;
    int seen [4];
    bit done = 0;
    string cur_req = "R1";
    exp_t q[$];

    always #(CLK_P/2) clk = ~clk;

    txch_td_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cfg_wr(cfg_wr),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .td_req(td_req),
        .work_busy(work_busy), .remote_sts(remote_sts), .xfer_err(xfer_err),
        .unpause(unpause), .drop_work(drop_work), .paused(paused),
        .td_marker(td_marker), .cpl_valid(cpl_valid), .cpl_qnum(cpl_qnum),
        .err_evt_valid(err_evt_valid), .err_evt_num(err_evt_num)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [15:0] data, input string req);
        exp_t e;
        e.kind = kind; e.data = data; e.req = req;
        q.push_back(e);
    endtask

    task automatic observe(input int kind, input logic [15:0] data);
        exp_t e;
        seen[kind]++;
        if (q.size() == 0) begin
            chk(0, {cur_req, " unexpected item"}, kind, -1);
        end else begin
            e = q.pop_front();
            chk(e.kind == kind && (kind == K_DROP || kind == K_MARK || e.data == data),
                e.req, (kind << 16) | data, (e.kind << 16) | e.data);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (drop_work)     observe(K_DROP, 16'h0);
            if (err_evt_valid) observe(K_EVT, err_evt_num);
            if (td_marker)     observe(K_MARK, 16'h0);
            if (cpl_valid)     observe(K_CPL, cpl_qnum);
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
        cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_wr = 0;
    endtask

    task automatic ch_on();
        chan_en = 1;
        tick(2);
    endtask

    task automatic ch_off();
        chan_en = 0;
        tick(2);
    endtask

    task automatic pulse_td();  td_req = 1;     tick(); td_req = 0;     endtask
    task automatic pulse_err(); xfer_err = 1;   tick(); xfer_err = 0;   endtask
    task automatic pulse_rem(); remote_sts = 1; tick(); remote_sts = 0; endtask
    task automatic pulse_unp(); unpause = 1;    tick(); unpause = 0;    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c0;
        foreach (seen[i]) seen[i] = 0;
        tick(3);
        rst_n = 1;
        tick();
        @(negedge clk);
        chk(!paused && !td_marker && !cpl_valid && !err_evt_valid && !drop_work,
            "R1 outputs idle", {paused, td_marker, cpl_valid, err_evt_valid, drop_work}, 0);
        tick();

        // Defaults: drop mode, event number FFFFh means no event
        cur_req = "R7";
        ch_on();
        push(K_DROP, 0, "R7 drop on error");
        pulse_err();
        tick(3);
        chk(paused == 0, "R7 stays active", paused, 0);
        chk(seen[K_EVT] == 0, "R1 reset event number suppresses event", seen[K_EVT], 0);

        // Teardown with busy drain, marker, immediate completion, qnum 0
        cur_req = "R2";
        work_busy = 1;
        pulse_td();
        tick(3);
        chk(seen[K_MARK] == 0, "R2 no marker while busy", seen[K_MARK], 0);
        push(K_MARK, 0, "R3 marker sent");
        push(K_CPL, 16'h0000, "R5 R6 immediate completion qnum");
        work_busy = 0;
        tick(4);
        chk(seen[K_CPL] == 1, "R5 immediate completion arrived", seen[K_CPL], 1);
        cur_req = "R13";
        pulse_td();
        tick(4);
        chk(seen[K_CPL] == 1, "R13 request ignored after completion", seen[K_CPL], 1);
        ch_off();

        // Marker suppressed, remote wait, locked config
        cur_req = "R4";
        cfg_write(2'd0, 16'h0003);
        cfg_write(2'd1, 16'h1234);
        cfg_write(2'd2, 16'h0042);
        ch_on();
        cfg_write(2'd1, 16'h5555);
        pulse_td();
        tick(5);
        chk(seen[K_CPL] == 1, "R5 completion held for remote", seen[K_CPL], 1);
        chk(seen[K_MARK] == 1, "R4 marker suppressed", seen[K_MARK], 1);
        push(K_CPL, 16'h1234, "R10 R6 qnum kept after locked write");
        pulse_rem();
        tick(3);
        chk(seen[K_CPL] == 2, "R5 completion after remote status", seen[K_CPL], 2);
        ch_off();

        // Pause on error, unpause, teardown while paused
        cur_req = "R8";
        cfg_write(2'd0, 16'h0004);
        ch_on();
        push(K_EVT, 16'h0042, "R9 event number");
        pulse_err();
        @(negedge clk);
        chk(paused == 1, "R8 paused after error", paused, 1);
        chk(seen[K_DROP] == 1, "R8 no drop in pause mode", seen[K_DROP], 1);
        tick();
        pulse_unp();
        @(negedge clk);
        chk(paused == 0, "R8 unpause clears", paused, 0);
        tick();
        push(K_EVT, 16'h0042, "R9 second event");
        pulse_err();
        tick(2);
        cur_req = "R11";
        push(K_CPL, 16'h1234, "R11 completion from paused");
        c0 = seen[K_MARK];
        pulse_td();
        @(negedge clk);
        chk(cpl_valid == 1, "R11 completion next cycle", cpl_valid, 1);
        tick(3);
        chk(seen[K_MARK] == c0, "R11 no marker from paused", seen[K_MARK], c0);
        ch_off();

        // Teardown and error in the same cycle
        cur_req = "R12";
        ch_on();
        cfg_write(2'd2, 16'h0099);
        push(K_EVT, 16'h0042, "R12 R10 event still emitted with locked number");
        push(K_MARK, 0, "R12 marker");
        push(K_CPL, 16'h1234, "R12 completion");
        td_req = 1; xfer_err = 1;
        tick();
        td_req = 0; xfer_err = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(paused == 0, "R12 never pauses", paused, 0);
            tick();
        end
        ch_off();

        chk(q.size() == 0, "R6 all expected items observed", q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule